// File: doc/BRIEF.md
# PCI Target Bus Rule Monitor

A passive observer for the target side of a conventional PCI bus. It watches the cycle-framing, initiator-ready, target-ready, device-claim and target-stop strobes together with the multiplexed address/data bus and the command/byte-enable lines. It never drives any of them. On every rising clock edge it decides whether a new transaction has begun and captures that transaction's address phase.

It then enforces two rules. The first is that no target may claim a transaction that carries a reserved command. The second is that once a transaction is under way, and as long as no data has moved and the bus has not gone idle, the target must end it with a retry within sixteen clocks. Each rule drives a one-cycle error pulse and an error flag that stays set until reset. Two more pulses report when a reserved command starts a transaction and when a retry is seen, so that coverage can be collected.

Top module: `pci_tgt_rule_mon`

## Requirements
- R1: While `rst_n` is low, every output is zero, and no rule is evaluated.
- R2: In a cycle where `cyc_act_n` is low and was high in the previous cycle, `adbus` and `cmdbe_n` are captured. They appear on `addr_q` and `cmd_q` one cycle later and are held unchanged at all other times.
- R3: A transaction start is a cycle in which `cyc_act_n` is low, `cyc_act_n` was high in the previous cycle, and `ini_rdy_n` is high. When a start carries a reserved command in `cmdbe_n[3:0]` (4'b0100, 4'b0101, 4'b1000 or 4'b1001), `rsvd_cov` is high for exactly the next cycle.
- R4: After a start with a reserved command, if `tgt_sel_n` is low in any of the four following cycles, `alias_err` is high in the cycle after that sample.
- R5: A start with a non-reserved command never raises `alias_err`. A claim in the fifth cycle after a reserved start also does not raise it.
- R6: Let a start be at offset 0. If `tgt_halt_n`, `tgt_sel_n` and `ini_rdy_n` are all low at some offset from 1 to 16, and every cycle from offset 1 up to that offset had the bus non-idle and `tgt_rdy_n` high, then `retry_seen` is high in the following cycle. Only the first such offset counts.
- R7: An idle cycle (`cyc_act_n` and `ini_rdy_n` both high) or a low `tgt_rdy_n` inside the window cancels the window. A cancelled window raises neither `retry_seen` nor `latency_err`.
- R8: If offsets 1 to 16 all pass with the bus non-idle, `tgt_rdy_n` high and no retry condition, `latency_err` is high in the cycle after offset 16.
- R9: A new start while either window is open closes the old window and opens a fresh one from the new start. The alias window is reloaded only if the new command is reserved.
- R10: `alias_err_sticky` and `latency_err_sticky` go high together with their pulses and stay high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all sampling on its rising edge |
| rst_n | input | 1 | Active-low reset of all monitor state |
| cyc_act_n | input | 1 | Cycle framing strobe, low while a transaction is in progress |
| ini_rdy_n | input | 1 | Initiator ready, active low |
| tgt_rdy_n | input | 1 | Target ready, active low |
| tgt_sel_n | input | 1 | Target claim (device select), active low |
| tgt_halt_n | input | 1 | Target stop request, active low |
| adbus | input | ADDR_W | Multiplexed address/data bus |
| cmdbe_n | input | ADDR_W/8 | Command / byte-enable lines |
| addr_q | output | ADDR_W | Captured address phase |
| cmd_q | output | ADDR_W/8 | Captured command lines |
| rsvd_cov | output | 1 | Pulse: a start carried a reserved command |
| alias_err | output | 1 | Pulse: a reserved command was claimed |
| alias_err_sticky | output | 1 | Held flag for the reserved-command rule |
| retry_seen | output | 1 | Pulse: a retry ended the window |
| latency_err | output | 1 | Pulse: the window expired without a retry |
| latency_err_sticky | output | 1 | Held flag for the retry-window rule |

## Verification
The assertions assume that the inputs are stable, known levels at each rising edge and that the bus is idle while reset is held. They assume nothing about protocol legality, because flagging illegal traffic is the monitor's job. The stimulus changes inputs only one time unit after an edge and holds an idle bus through every reset. Outside reset it is deliberately unconstrained, so that random strobe mixes reach overlapping starts, cancellations and expiries, while directed sequences place claims and retries at exact window offsets.

// File: rtl/pmon_pkg.sv
package pmon_pkg;
   localparam int CMD_W = 4;
   typedef logic [CMD_W-1:0] cmd_t;

   // Reserved command encodings on the low command nibble
   function automatic logic cmd_reserved(input cmd_t c);
      return (c == 4'b0100) || (c == 4'b0101) || (c == 4'b1000) || (c == 4'b1001);
   endfunction
endpackage

// File: rtl/pmon_phase_track.sv
module pmon_phase_track #(
   parameter int ADDR_W = 32,
   parameter int BE_W   = ADDR_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cyc_act_n,
   input  logic              ini_rdy_n,
   input  logic [ADDR_W-1:0] adbus,
   input  logic [BE_W-1:0]   cmdbe_n,
   output logic              first_o,
   output logic              start_o,
   output logic [ADDR_W-1:0] addr_q,
   output logic [BE_W-1:0]   cmd_q
);
   logic act_prev_n_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) act_prev_n_q <= 1'b1;
      else        act_prev_n_q <= cyc_act_n;
   end

   assign first_o = act_prev_n_q & ~cyc_act_n;
   assign start_o = first_o & ini_rdy_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         cmd_q  <= '0;
      end else if (first_o) begin
         addr_q <= adbus;
         cmd_q  <= cmdbe_n;
      end
   end
endmodule

// File: rtl/pmon_alias_chk.sv
module pmon_alias_chk #(
   parameter int HOLD       = 4,
   parameter bit SHIFT_IMPL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic rsvd_i,
   input  logic claim_n_i,
   output logic cov_o,
   output logic err_o,
   output logic sticky_o
);
   localparam int CW = $clog2(HOLD + 1);

   logic watch_w;
   logic viol_w;

   generate
      if (HOLD < 1) begin : g_bad_hold
         $error("pmon_alias_chk: HOLD must be at least 1");
      end
      if (SHIFT_IMPL) begin : g_shift
         logic [HOLD-1:0] pend_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       pend_q <= '0;
            else if (start_i) pend_q <= rsvd_i ? '1 : '0;
            else              pend_q <= pend_q >> 1;
         end
         assign watch_w = pend_q[0];
      end else begin : g_count
         logic [CW-1:0] left_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               left_q <= '0;
            else if (start_i)         left_q <= rsvd_i ? CW'(HOLD) : '0;
            else if (left_q != '0)    left_q <= left_q - 1'b1;
         end
         assign watch_w = (left_q != '0);
      end
   endgenerate

   assign viol_w = watch_w & ~start_i & ~claim_n_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cov_o    <= 1'b0;
         err_o    <= 1'b0;
         sticky_o <= 1'b0;
      end else begin
         cov_o    <= start_i & rsvd_i;
         err_o    <= viol_w;
         sticky_o <= sticky_o | viol_w;
      end
   end
endmodule

// File: rtl/pmon_retry_chk.sv
module pmon_retry_chk #(
   parameter int WIN = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic cyc_act_n,
   input  logic ini_rdy_n,
   input  logic tgt_rdy_n,
   input  logic tgt_sel_n,
   input  logic tgt_halt_n,
   output logic retry_o,
   output logic err_o,
   output logic sticky_o
);
   localparam int CW = $clog2(WIN + 1);

   logic [CW-1:0] off_q;
   logic open_w, eval_w, idle_w, cancel_w, hit_w, retry_w, late_w;

   generate
      if (WIN < 1) begin : g_bad_win
         $error("pmon_retry_chk: WIN must be at least 1");
      end
   endgenerate

   assign open_w   = (off_q != '0);
   assign eval_w   = open_w & ~start_i;
   assign idle_w   = cyc_act_n & ini_rdy_n;
   assign cancel_w = idle_w | ~tgt_rdy_n;
   assign hit_w    = ~tgt_halt_n & ~tgt_sel_n & ~ini_rdy_n;
   assign retry_w  = eval_w & ~cancel_w & hit_w;
   assign late_w   = eval_w & ~cancel_w & ~hit_w & (off_q == CW'(WIN));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                      off_q <= '0;
      else if (start_i)                                off_q <= CW'(1);
      else if (eval_w & (cancel_w | hit_w | late_w))   off_q <= '0;
      else if (eval_w)                                 off_q <= off_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         retry_o  <= 1'b0;
         err_o    <= 1'b0;
         sticky_o <= 1'b0;
      end else begin
         retry_o  <= retry_w;
         err_o    <= late_w;
         sticky_o <= sticky_o | late_w;
      end
   end
endmodule

// File: rtl/pci_tgt_rule_mon.sv
module pci_tgt_rule_mon #(
   parameter int ADDR_W      = 32,
   parameter int ALIAS_HOLD  = 4,
   parameter int RETRY_WIN   = 16,
   parameter bit ALIAS_SHIFT = 1'b0,
   localparam int BE_W       = ADDR_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cyc_act_n,
   input  logic              ini_rdy_n,
   input  logic              tgt_rdy_n,
   input  logic              tgt_sel_n,
   input  logic              tgt_halt_n,
   input  logic [ADDR_W-1:0] adbus,
   input  logic [BE_W-1:0]   cmdbe_n,
   output logic [ADDR_W-1:0] addr_q,
   output logic [BE_W-1:0]   cmd_q,
   output logic              rsvd_cov,
   output logic              alias_err,
   output logic              alias_err_sticky,
   output logic              retry_seen,
   output logic              latency_err,
   output logic              latency_err_sticky
);
   import pmon_pkg::*;

   logic first_w, start_w, rsvd_w;

   generate
      if ((ADDR_W % 32) != 0 || ADDR_W < 32) begin : g_bad_width
         $error("pci_tgt_rule_mon: ADDR_W must be a positive multiple of 32");
      end
   endgenerate

   pmon_phase_track #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_phase (
      .clk(clk), .rst_n(rst_n), .cyc_act_n(cyc_act_n), .ini_rdy_n(ini_rdy_n),
      .adbus(adbus), .cmdbe_n(cmdbe_n), .first_o(first_w), .start_o(start_w),
      .addr_q(addr_q), .cmd_q(cmd_q)
   );

   assign rsvd_w = cmd_reserved(cmdbe_n[CMD_W-1:0]);

   pmon_alias_chk #(.HOLD(ALIAS_HOLD), .SHIFT_IMPL(ALIAS_SHIFT)) u_alias (
      .clk(clk), .rst_n(rst_n), .start_i(start_w), .rsvd_i(rsvd_w),
      .claim_n_i(tgt_sel_n), .cov_o(rsvd_cov), .err_o(alias_err),
      .sticky_o(alias_err_sticky)
   );

   pmon_retry_chk #(.WIN(RETRY_WIN)) u_retry (
      .clk(clk), .rst_n(rst_n), .start_i(start_w), .cyc_act_n(cyc_act_n),
      .ini_rdy_n(ini_rdy_n), .tgt_rdy_n(tgt_rdy_n), .tgt_sel_n(tgt_sel_n),
      .tgt_halt_n(tgt_halt_n), .retry_o(retry_seen), .err_o(latency_err),
      .sticky_o(latency_err_sticky)
   );
endmodule

// File: rtl/pmon_checker.sv
module pmon_checker #(
   parameter int ADDR_W = 32,
   localparam int BE_W  = ADDR_W / 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cyc_act_n,
   input logic              ini_rdy_n,
   input logic              tgt_rdy_n,
   input logic              tgt_sel_n,
   input logic              tgt_halt_n,
   input logic [BE_W-1:0]   cmdbe_n,
   input logic [ADDR_W-1:0] addr_q,
   input logic              rsvd_cov,
   input logic              alias_err,
   input logic              alias_err_sticky,
   input logic              retry_seen,
   input logic              latency_err,
   input logic              latency_err_sticky
);
   import pmon_pkg::*;

   logic seen_idle_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_idle_q <= 1'b1;
      else        seen_idle_q <= cyc_act_n;
   end

   a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(seen_idle_q && !cyc_act_n) |=> $stable(addr_q));

   a_r3_cov_cause: assert property (@(posedge clk) disable iff (!rst_n)
      rsvd_cov |-> $past(seen_idle_q && !cyc_act_n && ini_rdy_n
                         && cmd_reserved(cmdbe_n[CMD_W-1:0])));

   a_r4_alias_claim: assert property (@(posedge clk) disable iff (!rst_n)
      alias_err |-> $past(!tgt_sel_n));

   a_r6_retry_cond: assert property (@(posedge clk) disable iff (!rst_n)
      retry_seen |-> $past(!tgt_halt_n && !tgt_sel_n && !ini_rdy_n && tgt_rdy_n));

   a_r8_late_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(retry_seen && latency_err));

   a_r10_alias_set: assert property (@(posedge clk) disable iff (!rst_n)
      alias_err |-> alias_err_sticky);

   a_r10_alias_hold: assert property (@(posedge clk) disable iff (!rst_n)
      alias_err_sticky |=> alias_err_sticky);

   a_r10_late_hold: assert property (@(posedge clk) disable iff (!rst_n)
      latency_err_sticky |=> latency_err_sticky);
endmodule

bind pci_tgt_rule_mon pmon_checker #(.ADDR_W(ADDR_W)) u_pmon_chk (
   .clk(clk), .rst_n(rst_n), .cyc_act_n(cyc_act_n), .ini_rdy_n(ini_rdy_n),
   .tgt_rdy_n(tgt_rdy_n), .tgt_sel_n(tgt_sel_n), .tgt_halt_n(tgt_halt_n),
   .cmdbe_n(cmdbe_n), .addr_q(addr_q), .rsvd_cov(rsvd_cov),
   .alias_err(alias_err), .alias_err_sticky(alias_err_sticky),
   .retry_seen(retry_seen), .latency_err(latency_err),
   .latency_err_sticky(latency_err_sticky)
);

// File: tb/pci_tgt_rule_mon_bench.sv
`timescale 1ns/1ps
module pci_tgt_rule_mon_bench;
   localparam int AW = 32;
   localparam int BW = AW / 8;
   localparam int HD = 18;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cyc_act_n = 1'b1, ini_rdy_n = 1'b1, tgt_rdy_n = 1'b1;
   logic tgt_sel_n = 1'b1, tgt_halt_n = 1'b1;
   logic [AW-1:0] adbus = '0;
   logic [BW-1:0] cmdbe_n = '1;
   logic [AW-1:0] addr_q;
   logic [BW-1:0] cmd_q;
   logic rsvd_cov, alias_err, alias_err_sticky, retry_seen, latency_err, latency_err_sticky;

   pci_tgt_rule_mon #(.ADDR_W(AW)) u_pci_tgt_rule_mon (
      .clk(clk), .rst_n(rst_n), .cyc_act_n(cyc_act_n), .ini_rdy_n(ini_rdy_n),
      .tgt_rdy_n(tgt_rdy_n), .tgt_sel_n(tgt_sel_n), .tgt_halt_n(tgt_halt_n),
      .adbus(adbus), .cmdbe_n(cmdbe_n), .addr_q(addr_q), .cmd_q(cmd_q),
      .rsvd_cov(rsvd_cov), .alias_err(alias_err), .alias_err_sticky(alias_err_sticky),
      .retry_seen(retry_seen), .latency_err(latency_err),
      .latency_err_sticky(latency_err_sticky)
   );

   always #2 clk = ~clk;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   string scen = "reset";

   // history, index 0 = most recent sampled cycle
   bit hf[HD], hi[HD], ht[HD], hd[HD], hs[HD], hst[HD], hr[HD];
   logic [AW-1:0] e_addr;
   logic [BW-1:0] e_cmd;
   bit e_cov, e_al, e_als, e_rt, e_lt, e_lts;

   function automatic bit ref_rsvd(input logic [3:0] c);
      case (c)
         4'h4, 4'h5, 4'h8, 4'h9: return 1'b1;
         default:                return 1'b0;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s [%s] actual=%0h expected=%0h", tag, scen, act, exp);
      end
   endtask

   task automatic clear_model();
      for (int k = 0; k < HD; k++) begin
         hf[k] = 1; hi[k] = 1; ht[k] = 1; hd[k] = 1; hs[k] = 1; hst[k] = 0; hr[k] = 0;
      end
      e_addr = '0; e_cmd = '0;
      {e_cov, e_al, e_als, e_rt, e_lt, e_lts} = '0;
   endtask

   function automatic bit idle_at(input int j);
      return hf[j] && hi[j];
   endfunction

   function automatic bit hit_at(input int j);
      return !hs[j] && !hd[j] && !hi[j];
   endfunction

   task automatic model_step();
      int k;
      bit ok;
      for (int m = HD - 1; m > 0; m--) begin
         hf[m] = hf[m-1]; hi[m] = hi[m-1]; ht[m] = ht[m-1]; hd[m] = hd[m-1];
         hs[m] = hs[m-1]; hst[m] = hst[m-1]; hr[m] = hr[m-1];
      end
      hf[0] = cyc_act_n; hi[0] = ini_rdy_n; ht[0] = tgt_rdy_n;
      hd[0] = tgt_sel_n; hs[0] = tgt_halt_n;
      hst[0] = hf[1] && !hf[0] && hi[0];
      hr[0]  = ref_rsvd(cmdbe_n[3:0]);
      if (hf[1] && !hf[0]) begin e_addr = adbus; e_cmd = cmdbe_n; end
      e_cov = hst[0] && hr[0];
      e_al = 0; e_rt = 0; e_lt = 0;
      if (!hst[0]) begin
         k = 0;
         for (int j = 16; j >= 1; j--) if (hst[j]) k = j;
         if (k != 0 && k <= 4 && hr[k] && !hd[0]) e_al = 1;
         if (k != 0) begin
            ok = 1;
            for (int j = 1; j < k; j++)
               if (idle_at(j) || !ht[j] || hit_at(j)) ok = 0;
            if (ok && !idle_at(0) && ht[0]) begin
               if (hit_at(0))    e_rt = 1;
               else if (k == 16) e_lt = 1;
            end
         end
      end
      e_als |= e_al;
      e_lts |= e_lt;
   endtask

   task automatic step();
      @(posedge clk); #1;
      model_step();
      chk("R2 addr", 64'(addr_q), 64'(e_addr));
      chk("R2 cmd", 64'(cmd_q), 64'(e_cmd));
      chk("R3 cov", 64'(rsvd_cov), 64'(e_cov));
      chk("R4 alias", 64'(alias_err), 64'(e_al));
      chk("R6 retry", 64'(retry_seen), 64'(e_rt));
      chk("R8 latency", 64'(latency_err), 64'(e_lt));
      chk("R10 alias sticky", 64'(alias_err_sticky), 64'(e_als));
      chk("R10 latency sticky", 64'(latency_err_sticky), 64'(e_lts));
   endtask

   task automatic drive(input bit f, input bit i, input bit t, input bit d, input bit s,
                        input logic [3:0] c);
      cyc_act_n = f; ini_rdy_n = i; tgt_rdy_n = t; tgt_sel_n = d; tgt_halt_n = s;
      cmdbe_n = {{(BW-4){1'b1}}, c};
      adbus = $urandom;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      drive(1, 1, 1, 1, 1, 4'hF);
      repeat (3) @(posedge clk);
      #1;
      clear_model();
      scen = "R1 reset";
      chk("R1 outputs", {addr_q, cmd_q, rsvd_cov, alias_err, alias_err_sticky,
                         retry_seen, latency_err, latency_err_sticky}, '0);
      rst_n = 1'b1;
      step();
   endtask

   task automatic finish_run();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog [%s] actual=running expected=finished", scen);
         finish_run();
      end
   end

   initial begin
      void'($urandom(32'd1234));
      clear_model();
      do_reset();

      // R4: reserved start, claim at offset 2
      scen = "R4 claim of reserved";
      drive(0, 1, 1, 1, 1, 4'b0100); step();
      chk("R3 cov directed", 64'(rsvd_cov), 64'd1);
      drive(0, 0, 1, 1, 1, 4'hF); step();
      drive(0, 0, 1, 0, 1, 4'hF); step();
      chk("R4 alias directed", 64'(alias_err), 64'd1);
      drive(0, 0, 1, 1, 1, 4'hF); step();
      chk("R10 sticky held", 64'(alias_err_sticky), 64'd1);

      // R5: non-reserved claim, and a claim in the fifth cycle
      do_reset();
      scen = "R5 non-reserved";
      drive(0, 1, 1, 1, 1, 4'b0110); step();
      for (int n = 0; n < 5; n++) begin drive(0, 0, 0, 0, 1, 4'hF); step(); end
      chk("R5 no alias", 64'(alias_err_sticky), 64'd0);
      drive(1, 1, 1, 1, 1, 4'hF); step();
      scen = "R5 fifth cycle";
      drive(0, 1, 1, 1, 1, 4'b1001); step();
      for (int n = 0; n < 4; n++) begin drive(0, 0, 0, 1, 1, 4'hF); step(); end
      drive(0, 0, 0, 0, 1, 4'hF); step();
      chk("R5 fifth claim ignored", 64'(alias_err_sticky), 64'd0);

      // R6: retry at offset 5
      do_reset();
      scen = "R6 retry";
      drive(0, 1, 1, 1, 1, 4'b0110); step();
      for (int n = 1; n < 5; n++) begin drive(0, 0, 1, 1, 1, 4'hF); step(); end
      drive(0, 0, 1, 0, 0, 4'hF); step();
      chk("R6 retry directed", 64'(retry_seen), 64'd1);
      for (int n = 0; n < 14; n++) begin drive(0, 0, 1, 1, 1, 4'hF); step(); end
      chk("R6 no latency after retry", 64'(latency_err_sticky), 64'd0);

      // R7: data transfer cancels, then idle cancels
      do_reset();
      scen = "R7 trdy cancel";
      drive(0, 1, 1, 1, 1, 4'b0110); step();
      drive(0, 0, 1, 1, 1, 4'hF); step();
      drive(0, 0, 0, 1, 1, 4'hF); step();
      for (int n = 0; n < 20; n++) begin drive(0, 0, 1, 1, 1, 4'hF); step(); end
      chk("R7 trdy cancels", 64'(latency_err_sticky), 64'd0);
      scen = "R7 idle cancel";
      drive(1, 1, 1, 1, 1, 4'hF); step();
      drive(0, 1, 1, 1, 1, 4'b0110); step();
      drive(0, 0, 1, 1, 1, 4'hF); step();
      drive(1, 1, 1, 1, 1, 4'hF); step();
      for (int n = 0; n < 20; n++) begin drive(1, 0, 1, 1, 1, 4'hF); step(); end
      chk("R7 idle cancels", 64'(latency_err_sticky), 64'd0);
      chk("R7 no retry", 64'(retry_seen), 64'd0);

      // R8: window expires
      do_reset();
      scen = "R8 expiry";
      drive(0, 1, 1, 1, 1, 4'b0010); step();
      for (int n = 1; n <= 16; n++) begin
         drive(0, 0, 1, 1, 1, 4'hF); step();
         if (n == 15) chk("R8 not before offset 16", 64'(latency_err), 64'd0);
         if (n == 16) chk("R8 latency directed", 64'(latency_err), 64'd1);
      end

      // R9: restarts
      do_reset();
      scen = "R9 alias restart";
      drive(0, 1, 1, 1, 1, 4'b0101); step();
      drive(1, 1, 1, 1, 1, 4'hF); step();
      drive(0, 1, 1, 1, 1, 4'b0011); step();
      for (int n = 0; n < 3; n++) begin drive(0, 0, 0, 0, 1, 4'hF); step(); end
      chk("R9 alias window closed", 64'(alias_err_sticky), 64'd0);
      do_reset();
      scen = "R9 retry restart";
      drive(0, 1, 1, 1, 1, 4'b0110); step();
      for (int n = 0; n < 9; n++) begin drive(0, 0, 1, 1, 1, 4'hF); step(); end
      drive(1, 0, 1, 1, 1, 4'hF); step();
      drive(0, 1, 1, 1, 1, 4'b0110); step();
      for (int n = 1; n <= 16; n++) begin
         drive(0, 0, 1, 1, 1, 4'hF); step();
         if (n == 15) chk("R9 old window gone", 64'(latency_err_sticky), 64'd0);
         if (n == 16) chk("R9 new window expires", 64'(latency_err), 64'd1);
      end

      // random traffic with model checking every cycle
      do_reset();
      scen = "random";
      for (int n = 0; n < 4000; n++) begin
         drive(($urandom % 4) != 0, ($urandom % 3) == 0, ($urandom % 8) != 0,
               ($urandom % 3) != 0, ($urandom % 4) != 0, 4'($urandom));
         step();
         if (n == 2000) do_reset();
      end

      done = 1'b1;
      finish_run();
   end
endmodule